// File: doc/BRIEF.md
# CAN Transmit Priority Arbiter

This block chooses which of a set of message buffers the CAN interface sends next. It also keeps four status bits for each buffer: pending, cancel request, acknowledge and abort-acknowledge. Software asks for a transmission by pulsing a buffer's set-pending bit, and withdraws the request by pulsing its cancel bit. Among the pending buffers that are not being cancelled, the arbiter picks the frame with the lowest identifier value. The chosen buffer index is held on `selIdx` while a one-cycle `loadStrobe` tells the transmit buffer to copy that message.

The CAN interface reports the end of each attempt as either a success pulse or a failure pulse. A failure covers both lost arbitration and a bus error. On success the buffer is retired with an acknowledge. On failure the block returns to arbitration, so a higher-priority frame that became pending in the meantime can win the next slot. Acknowledge and abort bits stay set until software writes 1 to clear them. A per-buffer mask decides which of these bits reach the two interrupt outputs.

Top module: `canTxPrioArb`

## Requirements
- R1: A 1 on `hostSetPend[i]` sets pending bit i at the next clock edge. Pending stays set until buffer i completes or is aborted. If a host set and a clear of the same pending bit fall in one cycle, the host set wins.
- R2: The candidates are the buffers with pending set and cancel clear. The buffer chosen is the candidate with the numerically lowest identifier, taken from `bufIdFlat[i*ID_W +: ID_W]`. When identifiers are equal, the lower buffer index wins.
- R3: When nothing is loaded and a candidate exists, the next edge sets `selValid`, places the winner on `selIdx`, and raises `loadStrobe` for exactly one cycle.
- R4: A `txDone` pulse while a buffer is loaded clears that buffer's pending and cancel bits, sets its acknowledge bit, and drops `selValid`. `txDone` and `txFail` have no effect when nothing is loaded.
- R5: A `txFail` pulse while a buffer is loaded (and `txDone` low) drops `selValid` and keeps pending. Arbitration then runs again on the current candidates, so the winner is loaded two edges after the failure pulse.
- R6: A 1 on `hostSetCancel[i]` is accepted only while pending bit i is set; otherwise it has no effect. A cancel on a buffer that is not loaded clears pending and cancel and sets abort-acknowledge one edge after the cancel bit is set.
- R7: A cancel on the loaded buffer waits for the attempt to end. A success gives acknowledge with no abort. A failure clears pending and cancel and sets abort-acknowledge.
- R8: A 1 on `hostClrAck[i]` or `hostClrAbort[i]` clears the matching bit at the next edge. If the block sets that bit in the same cycle, the set wins.
- R9: `ackIrq` is the OR over all buffers of acknowledge with the mask bit clear. `abortIrq` is the same for abort-acknowledge. An `irqMask` bit of 1 blocks that buffer.
- R10: After reset, all status bits, `selValid`, `loadStrobe` and both interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostSetPend | input | NUM_BUF | Per-buffer set-pending pulses |
| hostSetCancel | input | NUM_BUF | Per-buffer cancel-request pulses |
| hostClrAck | input | NUM_BUF | Write-1-to-clear for acknowledge bits |
| hostClrAbort | input | NUM_BUF | Write-1-to-clear for abort-acknowledge bits |
| irqMask | input | NUM_BUF | 1 blocks that buffer from both interrupts |
| bufIdFlat | input | NUM_BUF*ID_W | Identifier of each buffer, buffer i at i*ID_W |
| txDone | input | 1 | Current frame was sent successfully |
| txFail | input | 1 | Current frame lost arbitration or hit an error |
| selValid | output | 1 | A buffer is loaded in the transmit path |
| selIdx | output | $clog2(NUM_BUF) | Index of the loaded buffer |
| loadStrobe | output | 1 | One-cycle pulse to copy the selected buffer |
| pendStat | output | NUM_BUF | Pending bits |
| cancelStat | output | NUM_BUF | Cancel request bits |
| ackStat | output | NUM_BUF | Acknowledge bits |
| abortStat | output | NUM_BUF | Abort-acknowledge bits |
| ackIrq | output | 1 | Unmasked acknowledge interrupt |
| abortIrq | output | 1 | Unmasked abort interrupt |

## Verification
Two pairs of events can land on the same buffer in the same cycle. The first is the completion of the loaded buffer together with a host write-1 clear of its acknowledge bit. The second is a cancel that arrives while that buffer is loaded and is followed by either outcome of the attempt. Directed sequences create each collision on purpose. A long random phase produces them again alongside set-pending pulses on the same buffer. A behavioural model in the bench decides the outcome, and the design is compared against it on every clock: the set must win over the clear, and only a failed attempt may turn a cancel into an abort.

// File: rtl/canTxArbPkg.sv
package canTxArbPkg;

  // Strobes from the sequencer into the status datapath
  typedef struct packed {
    logic latchWin;  // capture arbitration winner as loaded buffer
    logic finOk;     // loaded buffer finished successfully
    logic finFail;   // loaded buffer attempt failed
  } arbStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } arbState_t;

endpackage

// File: rtl/canTxArbTree.sv
module canTxArbTree #(
  parameter int NUM  = 32,
  parameter int ID_W = 11,
  localparam int IDX_W = $clog2(NUM),
  localparam int LVLS  = $clog2(NUM)
) (
  input  logic [NUM-1:0]      cand,
  input  logic [NUM*ID_W-1:0] idFlat,
  output logic                anyCand,
  output logic [IDX_W-1:0]    winIdx
);

  // Tournament tree: each level halves the field, lower index kept on ties
  for (genvar l = 0; l <= LVLS; l++) begin : gLvl
    localparam int CNT = NUM >> l;
    logic [CNT-1:0] vld;
    logic [ID_W-1:0]  idv [CNT];
    logic [IDX_W-1:0] ix  [CNT];
    if (l == 0) begin : gLeaf
      for (genvar i = 0; i < CNT; i++) begin : gIn
        assign vld[i] = cand[i];
        assign idv[i] = idFlat[i*ID_W +: ID_W];
        assign ix[i]  = IDX_W'(i);
      end
    end else begin : gNode
      for (genvar i = 0; i < CNT; i++) begin : gPair
        logic takeLeft;
        assign takeLeft = gLvl[l-1].vld[2*i] &&
                          (!gLvl[l-1].vld[2*i+1] ||
                           (gLvl[l-1].idv[2*i] <= gLvl[l-1].idv[2*i+1]));
        assign vld[i] = gLvl[l-1].vld[2*i] | gLvl[l-1].vld[2*i+1];
        assign idv[i] = takeLeft ? gLvl[l-1].idv[2*i] : gLvl[l-1].idv[2*i+1];
        assign ix[i]  = takeLeft ? gLvl[l-1].ix[2*i]  : gLvl[l-1].ix[2*i+1];
      end
    end
  end

  assign anyCand = gLvl[LVLS].vld[0];
  assign winIdx  = gLvl[LVLS].ix[0];

endmodule

// File: rtl/canTxArbCtrl.sv
module canTxArbCtrl
  import canTxArbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyCand,
  input  logic       txDone,
  input  logic       txFail,
  output arbStrobe_t strobe,
  output logic       busy,
  output logic       loadStrobe
);

  arbState_t state;

  always_comb begin
    strobe = '0;
    case (state)
      ST_IDLE: strobe.latchWin = anyCand;
      ST_BUSY: begin
        strobe.finOk   = txDone;
        strobe.finFail = !txDone && txFail;
      end
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      loadStrobe <= 1'b0;
    end else begin
      loadStrobe <= strobe.latchWin;
      if (strobe.latchWin)
        state <= ST_BUSY;
      else if (strobe.finOk || strobe.finFail)
        state <= ST_IDLE;
    end
  end

  assign busy = (state == ST_BUSY);

  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |=> !loadStrobe); // R3
  AST_LOAD_WITH_SEL: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |-> busy); // R3
  AST_END_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finOk || strobe.finFail) |=> !busy); // R5

endmodule

// File: rtl/canTxArbStatus.sv
module canTxArbStatus
  import canTxArbPkg::*;
#(
  parameter int NUM = 32,
  localparam int IDX_W = $clog2(NUM)
) (
  input  logic             clk,
  input  logic             rstN,
  input  arbStrobe_t       strobe,
  input  logic             busy,
  input  logic [NUM-1:0]   hostSetPend,
  input  logic [NUM-1:0]   hostSetCancel,
  input  logic [NUM-1:0]   hostClrAck,
  input  logic [NUM-1:0]   hostClrAbort,
  input  logic             anyCand,
  input  logic [IDX_W-1:0] winIdx,
  output logic [NUM-1:0]   cand,
  output logic [NUM-1:0]   pend,
  output logic [NUM-1:0]   cancel,
  output logic [NUM-1:0]   ack,
  output logic [NUM-1:0]   abortAck,
  output logic [IDX_W-1:0] curIdx
);

  logic [NUM-1:0] curOh, loadedVec, okVec, failVec;
  logic [NUM-1:0] abortNow, pendClr;

  assign curOh     = NUM'(1) << curIdx;
  assign loadedVec = busy ? curOh : '0;
  assign okVec     = strobe.finOk ? curOh : '0;
  assign failVec   = strobe.finFail ? curOh : '0;

  // A cancel resolves at once when not loaded, else only on a failed attempt
  assign abortNow = cancel & (~loadedVec | failVec);
  assign pendClr  = okVec | abortNow;
  assign cand     = pend & ~cancel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend     <= '0;
      cancel   <= '0;
      ack      <= '0;
      abortAck <= '0;
      curIdx   <= '0;
    end else begin
      pend     <= (pend & ~pendClr) | hostSetPend;
      cancel   <= (cancel | (hostSetCancel & pend)) & ~pendClr;
      ack      <= (ack & ~hostClrAck) | okVec;
      abortAck <= (abortAck & ~hostClrAbort) | abortNow;
      if (strobe.latchWin)
        curIdx <= winIdx;
    end
  end

  AST_CANCEL_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    (cancel & ~pend) == '0); // R6
  AST_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rstN)
    anyCand |-> cand[winIdx]); // R2
  AST_DONE_SETS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finOk |=> ack[$past(curIdx)]); // R4

endmodule

// File: rtl/canTxPrioArb.sv
module canTxPrioArb
  import canTxArbPkg::*;
#(
  parameter int NUM_BUF = 32,
  parameter int ID_W    = 11,
  localparam int IDX_W  = $clog2(NUM_BUF)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_BUF-1:0]      hostSetPend,
  input  logic [NUM_BUF-1:0]      hostSetCancel,
  input  logic [NUM_BUF-1:0]      hostClrAck,
  input  logic [NUM_BUF-1:0]      hostClrAbort,
  input  logic [NUM_BUF-1:0]      irqMask,
  input  logic [NUM_BUF*ID_W-1:0] bufIdFlat,
  input  logic                    txDone,
  input  logic                    txFail,
  output logic                    selValid,
  output logic [IDX_W-1:0]        selIdx,
  output logic                    loadStrobe,
  output logic [NUM_BUF-1:0]      pendStat,
  output logic [NUM_BUF-1:0]      cancelStat,
  output logic [NUM_BUF-1:0]      ackStat,
  output logic [NUM_BUF-1:0]      abortStat,
  output logic                    ackIrq,
  output logic                    abortIrq
);

  arbStrobe_t         strobe;
  logic               busy, anyCand;
  logic [IDX_W-1:0]   winIdx, curIdx;
  logic [NUM_BUF-1:0] cand;

  canTxArbTree #(.NUM(NUM_BUF), .ID_W(ID_W)) tree_i (
    .cand(cand), .idFlat(bufIdFlat), .anyCand(anyCand), .winIdx(winIdx)
  );

  canTxArbCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .anyCand(anyCand), .txDone(txDone),
    .txFail(txFail), .strobe(strobe), .busy(busy), .loadStrobe(loadStrobe)
  );

  canTxArbStatus #(.NUM(NUM_BUF)) stat_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(busy),
    .hostSetPend(hostSetPend), .hostSetCancel(hostSetCancel),
    .hostClrAck(hostClrAck), .hostClrAbort(hostClrAbort),
    .anyCand(anyCand), .winIdx(winIdx), .cand(cand),
    .pend(pendStat), .cancel(cancelStat), .ack(ackStat),
    .abortAck(abortStat), .curIdx(curIdx)
  );

  assign selValid = busy;
  assign selIdx   = curIdx;
  assign ackIrq   = |(ackStat & ~irqMask);
  assign abortIrq = |(abortStat & ~irqMask);

endmodule

// File: tb/canTxPrioArb_tb.sv
module canTxPrioArb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 32;
  localparam int IW = 11;
  localparam int XW = $clog2(N);

  logic clk = 1'b0, rstN = 1'b0;
  logic [N-1:0] setP = '0, setC = '0, clrA = '0, clrB = '0, mask = '0;
  logic [N*IW-1:0] idFlat;
  logic txDone = 1'b0, txFail = 1'b0;
  logic selValid, loadStrobe, ackIrq, abortIrq;
  logic [XW-1:0] selIdx;
  logic [N-1:0] pendS, cancS, ackS, abtS;

  int ids [N];
  int nChecks = 0, nFail = 0;
  bit started = 0;

  // reference model state
  logic [N-1:0] mPend, mCanc, mAck, mAbt;
  bit mBusy, mLoad;
  int mCur;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) idFlat[i*IW +: IW] = IW'(ids[i]);

  canTxPrioArb #(.NUM_BUF(N), .ID_W(IW)) dut_i (
    .clk(clk), .rstN(rstN), .hostSetPend(setP), .hostSetCancel(setC),
    .hostClrAck(clrA), .hostClrAbort(clrB), .irqMask(mask), .bufIdFlat(idFlat),
    .txDone(txDone), .txFail(txFail), .selValid(selValid), .selIdx(selIdx),
    .loadStrobe(loadStrobe), .pendStat(pendS), .cancelStat(cancS),
    .ackStat(ackS), .abortStat(abtS), .ackIrq(ackIrq), .abortIrq(abortIrq)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model, stepped on each rising edge
  always @(posedge clk) begin
    int best;
    bit ok, fl, loaded, abortNow, clr;
    logic [N-1:0] nP, nC, nA, nB;
    started <= 1;
    if (!rstN) begin
      mPend <= '0; mCanc <= '0; mAck <= '0; mAbt <= '0;
      mBusy <= 0; mLoad <= 0; mCur <= 0;
    end else begin
      best = -1;
      for (int i = 0; i < N; i++)
        if (mPend[i] && !mCanc[i] && (best < 0 || ids[i] < ids[best])) best = i;
      ok = mBusy && txDone;
      fl = mBusy && !txDone && txFail;
      for (int i = 0; i < N; i++) begin
        loaded   = mBusy && (mCur == i);
        abortNow = mCanc[i] && (!loaded || fl);
        clr      = (loaded && ok) || abortNow;
        nP[i] = (mPend[i] && !clr) || setP[i];
        nC[i] = !clr && (mCanc[i] || (setC[i] && mPend[i]));
        nA[i] = (mAck[i] && !clrA[i]) || (loaded && ok);
        nB[i] = (mAbt[i] && !clrB[i]) || abortNow;
      end
      mPend <= nP; mCanc <= nC; mAck <= nA; mAbt <= nB;
      mLoad <= (!mBusy && best >= 0);
      if (!mBusy && best >= 0) begin mBusy <= 1; mCur <= best; end
      else if (ok || fl) mBusy <= 0;
    end
  end

  // compare every cycle away from the rising edge
  always @(negedge clk) if (started) begin
    if (!rstN) begin
      chk({selValid, loadStrobe, pendS, cancS, ackS, abtS, ackIrq, abortIrq} == '0,
          "R10 reset state", {pendS, ackS}, 64'h0);
    end else begin
      chk(selValid == mBusy, "R3 selValid", 64'(selValid), 64'(mBusy));
      if (mBusy) chk(selIdx == XW'(mCur), "R2 selIdx", 64'(selIdx), 64'(mCur));
      chk(loadStrobe == mLoad, "R3 loadStrobe", 64'(loadStrobe), 64'(mLoad));
      chk(pendS == mPend, "R1 pending", 64'(pendS), 64'(mPend));
      chk(cancS == mCanc, "R6 cancel", 64'(cancS), 64'(mCanc));
      chk(ackS == mAck, "R4 ack", 64'(ackS), 64'(mAck));
      chk(abtS == mAbt, "R7 abort", 64'(abtS), 64'(mAbt));
      chk(ackIrq == |(mAck & ~mask), "R9 ackIrq", 64'(ackIrq), 64'(|(mAck & ~mask)));
      chk(abortIrq == |(mAbt & ~mask), "R9 abortIrq", 64'(abortIrq), 64'(|(mAbt & ~mask)));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    setP = '0; setC = '0; clrA = '0; clrB = '0; txDone = 0; txFail = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++; nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) ids[i] = 2000 - i * 7;
    ids[3] = 400; ids[5] = 50; ids[9] = 50; ids[20] = 50;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    tick();
    // R6: cancel of a non-pending buffer is dropped
    setC[7] = 1; tick(); tick();
    chk(cancS[7] == 0 && abtS[7] == 0, "R6 cancel ignored", 64'({cancS[7], abtS[7]}), 64'h0);
    // R4: completion pulses with nothing loaded do nothing
    txDone = 1; tick(); txFail = 1; tick();
    chk(ackS == '0 && abtS == '0 && !selValid, "R4 idle ignored", 64'(ackS), 64'h0);
    // R3: single request loads after two edges
    setP[3] = 1; tick(); tick();
    chk(loadStrobe && selValid && selIdx == 3, "R3 load", 64'(selIdx), 64'd3);
    // R5: higher priority arrives, failure re-arbitrates
    setP[5] = 1; setP[9] = 1; setP[20] = 1; tick();
    txFail = 1; tick(); tick();
    chk(selValid && selIdx == 5 && pendS[3], "R5 rearbitrate", 64'(selIdx), 64'd5);
    // R4: success retires
    txDone = 1; tick();
    chk(ackS[5] && !pendS[5] && !selValid, "R4 done", 64'({ackS[5], pendS[5]}), 64'h2);
    tick();
    chk(selIdx == 9, "R2 tie lower index", 64'(selIdx), 64'd9);
    // R7: cancel loaded then failure gives abort
    setC[9] = 1; tick(); txFail = 1; tick();
    chk(abtS[9] && !pendS[9] && !cancS[9], "R7 abort on fail", 64'(abtS[9]), 64'd1);
    tick();
    chk(selIdx == 20, "R2 lowest id", 64'(selIdx), 64'd20);
    // R7: cancel loaded then success gives ack
    setC[20] = 1; tick(); txDone = 1; tick();
    chk(ackS[20] && !abtS[20], "R7 ack wins", 64'({ackS[20], abtS[20]}), 64'h2);
    tick();
    // R6: cancel of an unloaded pending buffer
    setP[12] = 1; tick(); setC[12] = 1; tick(); tick();
    chk(abtS[12] && !pendS[12], "R6 abort unloaded", 64'(abtS[12]), 64'd1);
    // R8: completion and host clear on the same buffer, set wins
    txDone = 1; clrA[3] = 1; tick();
    chk(ackS[3] == 1, "R8 set beats clear", 64'(ackS[3]), 64'd1);
    clrA[3] = 1; tick();
    chk(ackS[3] == 0, "R8 clear", 64'(ackS[3]), 64'd0);
    // R9: masking
    mask = '1; tick();
    chk(!ackIrq && !abortIrq, "R9 masked", 64'({ackIrq, abortIrq}), 64'h0);
    mask[5] = 0; tick();
    chk(ackIrq, "R9 unmasked", 64'(ackIrq), 64'd1);
    // random phase, model compared each cycle
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < N; i++) begin
        setP[i] = ($urandom_range(0, 15) == 0);
        setC[i] = ($urandom_range(0, 40) == 0);
        clrA[i] = ($urandom_range(0, 10) == 0);
        clrB[i] = ($urandom_range(0, 10) == 0);
      end
      txDone = ($urandom_range(0, 3) == 0);
      txFail = ($urandom_range(0, 4) == 0);
      if ($urandom_range(0, 50) == 0) mask = N'($urandom());
      if ($urandom_range(0, 200) == 0) ids[$urandom_range(0, N-1)] = $urandom_range(0, 2047);
      @(posedge clk); #1;
    end
    tick(); tick();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule